// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block sits in each port of a storage host controller. It turns the command-issue bitmap that software writes into requests to one shared command engine. While the port is started, it walks the pending slots from the lowest number to the highest. It offers one slot at a time on a request/acknowledge handshake. The fetch logic answers the acknowledge with four header bytes from that slot's command frame: type, flags, command and tag.

The block sorts each frame into one of three kinds:

- **Rejected.** The frame is dropped without running.
- **Plain.** The frame is started on the engine. If the engine stays busy afterwards, the slot is held as the single outstanding busy slot until the engine goes idle.
- **Queued.** The frame is tracked by its tag in an active-tag bitmap. Completions for queued frames arrive later with a tag and an error flag. They build a finished mask and an error mask, and they update the task-file status and error bytes.

A read of the active-tag view drops every finished tag from the active set and then empties the finished mask.

Top module: `slot_dispatch_sched`

## Requirements
- R1: A slot is offered (`disp_req` high, `disp_slot` = slot number) only while `start` is 1 and the issue bitmap is nonzero, and the lowest-numbered set slot is always offered first.
- R2: A write on `issue_wr` ORs `issue_wdata` into the issue bitmap, and a zero write leaves set bits set.
- R3: No slot is offered while `eng_bsy` or `eng_drq` is 1, and the pending issue bits remain set until the engine is idle.
- R4: A plain command after which the engine is idle in the cycle following `exec_go` has its issue bit cleared in that same cycle.
- R5: A plain command after which the engine is busy (BSY or DRQ) becomes the busy slot (`busy_valid`=1, `busy_slot`). Its issue bit stays set until the first cycle in which both BSY and DRQ are 0. In that cycle the bit is cleared and `busy_valid` returns to 0.
- R6: Only a frame with type byte 0x27 and flag byte exactly 0x80 is accepted. Any other frame gives a one-cycle `disp_reject` with no `exec_go` or `q_go`, and its issue bit is cleared.
- R7: An accepted frame with command byte 0x60 or 0x61 is queued. Its tag is tag byte bits 7:3. A free tag gives `q_go` with `q_tag`, sets the tag's active bit and clears the issue bit. A tag already in use gives `tag_conflict` instead, and the active bits are left unchanged.
- R8: A completion (`cpl_valid`, `cpl_tag`) clears the tag's active bit, frees the tag and sets its bit in `fin_map`. With `cpl_err`=1 it also sets the tag's bit in `err_map` and sets status 0x41 and error 0x04. Without an error it sets status 0x50 and leaves the error byte unchanged.
- R9: `act_rdata` shows the active bits with finished tags removed. A cycle with `act_rd`=1 removes the finished tags from the active bitmap and zeroes `fin_map`.
- R10: While a busy slot is held, no further slot is offered.
- R11: `port_rst` empties the issue bitmap, the active bitmap, the finished mask and all tag-in-use flags, and drops the busy slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_rst | input | 1 | Synchronous port reset |
| start | input | 1 | Port started; enables scanning |
| issue_wr | input | 1 | Write strobe for the issue register |
| issue_wdata | input | NUM_SLOTS | Bits ORed into the issue bitmap |
| eng_bsy | input | 1 | Engine busy status |
| eng_drq | input | 1 | Engine data-request status |
| disp_req | output | 1 | A slot is offered for dispatch |
| disp_slot | output | SLOT_W | Slot being offered |
| disp_ack | input | 1 | Header bytes of the offered slot are valid |
| hdr_type | input | 8 | Frame type byte |
| hdr_flags | input | 8 | Frame flag byte |
| hdr_cmd | input | 8 | Command byte |
| hdr_tag | input | 8 | Tag byte (tag in bits 7:3) |
| exec_go | output | 1 | Plain command started on the engine |
| q_go | output | 1 | Queued command accepted |
| q_tag | output | TAG_W | Tag of the accepted queued command |
| disp_reject | output | 1 | Frame rejected |
| tag_conflict | output | 1 | Queued command named a tag in use |
| issue_map | output | NUM_SLOTS | Current issue bitmap |
| busy_valid | output | 1 | A busy slot is held |
| busy_slot | output | SLOT_W | Held busy slot |
| cpl_valid | input | 1 | Queued completion strobe |
| cpl_tag | input | TAG_W | Completed tag |
| cpl_err | input | 1 | Completion ended in error |
| act_rd | input | 1 | Read strobe of the active-tag view |
| act_rdata | output | NUM_TAGS | Active tags minus finished tags |
| fin_map | output | NUM_TAGS | Finished-tag mask |
| err_map | output | NUM_TAGS | Error-tag mask |
| tf_status | output | 8 | Task-file status byte |
| tf_error | output | 8 | Task-file error byte |

## Verification
The assertions assume four things about the environment:

- `disp_ack` arrives only while `disp_req` is high.
- A completion names only a tag that was accepted earlier.
- `port_rst` is not raised in the same cycle as an issue write.
- BSY is raised only in reply to `exec_go`.

The stimulus keeps to these rules. It acknowledges only after it sees the request, and it completes only tags it has queued. It drives the engine status from the bench's own model of a command that finishes at once or one that stays busy for a set number of cycles.

// File: rtl/sds_pkg.sv
package sds_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_SETTLE} sched_st_e;
    typedef enum logic [1:0] {HK_REJECT, HK_PLAIN, HK_QUEUED} hdr_kind_e;

    localparam logic [7:0] FIS_H2D_REG  = 8'h27;
    localparam logic [7:0] FLG_CMD_UPD  = 8'h80;
    localparam logic [7:0] CMD_Q_READ   = 8'h60;
    localparam logic [7:0] CMD_Q_WRITE  = 8'h61;
    localparam logic [7:0] STS_READY    = 8'h40;
    localparam logic [7:0] STS_SEEK     = 8'h10;
    localparam logic [7:0] STS_ERR      = 8'h01;
    localparam logic [7:0] ERR_ABORT    = 8'h04;
endpackage

// File: rtl/sds_slot_pick.sv
module sds_slot_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        found = |req;
    end
endmodule

// File: rtl/sds_hdr_decode.sv
module sds_hdr_decode
    import sds_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic [7:0]       hdr_type,
    input  logic [7:0]       hdr_flags,
    input  logic [7:0]       hdr_cmd,
    input  logic [7:0]       hdr_tag,
    output hdr_kind_e        kind,
    output logic [TAG_W-1:0] tag
);
    logic unused_tag_bits;
    assign unused_tag_bits = ^hdr_tag;
    assign tag = hdr_tag[3 +: TAG_W];

    always_comb begin
        if (hdr_type != FIS_H2D_REG || hdr_flags != FLG_CMD_UPD)
            kind = HK_REJECT;
        else if (hdr_cmd == CMD_Q_READ || hdr_cmd == CMD_Q_WRITE)
            kind = HK_QUEUED;
        else
            kind = HK_PLAIN;
    end
endmodule

// File: rtl/sds_tag_track.sv
module sds_tag_track
    import sds_pkg::*;
#(
    parameter int NUM_TAGS = 32,
    parameter int TAG_W    = $clog2(NUM_TAGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                q_try,
    input  logic [TAG_W-1:0]    q_tag,
    output logic                q_clash,
    input  logic                cpl_valid,
    input  logic [TAG_W-1:0]    cpl_tag,
    input  logic                cpl_err,
    input  logic                act_rd,
    output logic [NUM_TAGS-1:0] act_rdata,
    output logic [NUM_TAGS-1:0] fin_map,
    output logic [NUM_TAGS-1:0] err_map,
    output logic [7:0]          tf_status,
    output logic [7:0]          tf_error
);
    typedef struct packed {
        logic [NUM_TAGS-1:0] act;
        logic [NUM_TAGS-1:0] fin;
        logic [NUM_TAGS-1:0] used;
        logic [NUM_TAGS-1:0] err;
        logic [7:0]          sts;
        logic [7:0]          erb;
    } trk_t;

    trk_t trk_q, trk_d;

    assign q_clash = trk_q.used[q_tag];

    always_comb begin
        trk_d = trk_q;
        if (act_rd) begin
            trk_d.act = trk_q.act & ~trk_q.fin;
            trk_d.fin = '0;
        end
        if (q_try && !trk_q.used[q_tag]) begin
            trk_d.used[q_tag] = 1'b1;
            trk_d.act[q_tag]  = 1'b1;
        end
        if (cpl_valid) begin
            trk_d.act[cpl_tag]  = 1'b0;
            trk_d.used[cpl_tag] = 1'b0;
            trk_d.fin[cpl_tag]  = 1'b1;
            if (cpl_err) begin
                trk_d.err[cpl_tag] = 1'b1;
                trk_d.sts = STS_READY | STS_ERR;
                trk_d.erb = ERR_ABORT;
            end else begin
                trk_d.sts = STS_READY | STS_SEEK;
            end
        end
        if (clr) begin
            trk_d.act  = '0;
            trk_d.fin  = '0;
            trk_d.used = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign act_rdata = trk_q.act & ~trk_q.fin;
    assign fin_map   = trk_q.fin;
    assign err_map   = trk_q.err;
    assign tf_status = trk_q.sts;
    assign tf_error  = trk_q.erb;
endmodule

// File: rtl/slot_dispatch_sched.sv
module slot_dispatch_sched
    import sds_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_TAGS  = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int TAG_W     = $clog2(NUM_TAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 port_rst,
    input  logic                 start,
    input  logic                 issue_wr,
    input  logic [NUM_SLOTS-1:0] issue_wdata,
    input  logic                 eng_bsy,
    input  logic                 eng_drq,
    output logic                 disp_req,
    output logic [SLOT_W-1:0]    disp_slot,
    input  logic                 disp_ack,
    input  logic [7:0]           hdr_type,
    input  logic [7:0]           hdr_flags,
    input  logic [7:0]           hdr_cmd,
    input  logic [7:0]           hdr_tag,
    output logic                 exec_go,
    output logic                 q_go,
    output logic [TAG_W-1:0]     q_tag,
    output logic                 disp_reject,
    output logic                 tag_conflict,
    output logic [NUM_SLOTS-1:0] issue_map,
    output logic                 busy_valid,
    output logic [SLOT_W-1:0]    busy_slot,
    input  logic                 cpl_valid,
    input  logic [TAG_W-1:0]     cpl_tag,
    input  logic                 cpl_err,
    input  logic                 act_rd,
    output logic [NUM_TAGS-1:0]  act_rdata,
    output logic [NUM_TAGS-1:0]  fin_map,
    output logic [NUM_TAGS-1:0]  err_map,
    output logic [7:0]           tf_status,
    output logic [7:0]           tf_error
);
    typedef struct packed {
        sched_st_e            st;
        logic [NUM_SLOTS-1:0] issue;
        logic [SLOT_W-1:0]    cur;
        logic                 bvalid;
        logic [SLOT_W-1:0]    bslot;
        logic                 exec_go;
        logic                 q_go;
        logic [TAG_W-1:0]     q_tag;
        logic                 reject;
        logic                 clash;
    } sched_t;

    sched_t q, d;

    logic                 pick_found;
    logic [SLOT_W-1:0]    pick_idx;
    hdr_kind_e            kind;
    logic [TAG_W-1:0]     dec_tag;
    logic                 q_try;
    logic                 q_clash;
    logic                 eng_idle;
    logic [NUM_SLOTS-1:0] clr;

    sds_slot_pick #(.N(NUM_SLOTS), .IW(SLOT_W)) u_pick (
        .req   (q.issue),
        .found (pick_found),
        .idx   (pick_idx)
    );

    sds_hdr_decode #(.TAG_W(TAG_W)) u_dec (
        .hdr_type  (hdr_type),
        .hdr_flags (hdr_flags),
        .hdr_cmd   (hdr_cmd),
        .hdr_tag   (hdr_tag),
        .kind      (kind),
        .tag       (dec_tag)
    );

    assign eng_idle = !eng_bsy && !eng_drq;
    assign q_try    = (q.st == ST_REQ) && disp_ack && (kind == HK_QUEUED) && !port_rst;

    sds_tag_track #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (port_rst),
        .q_try     (q_try),
        .q_tag     (dec_tag),
        .q_clash   (q_clash),
        .cpl_valid (cpl_valid),
        .cpl_tag   (cpl_tag),
        .cpl_err   (cpl_err),
        .act_rd    (act_rd),
        .act_rdata (act_rdata),
        .fin_map   (fin_map),
        .err_map   (err_map),
        .tf_status (tf_status),
        .tf_error  (tf_error)
    );

    always_comb begin
        d         = q;
        d.exec_go = 1'b0;
        d.q_go    = 1'b0;
        d.reject  = 1'b0;
        d.clash   = 1'b0;
        clr       = '0;

        unique case (q.st)
            ST_IDLE: begin
                if (start && pick_found && eng_idle && !q.bvalid) begin
                    d.st  = ST_REQ;
                    d.cur = pick_idx;
                end
            end
            ST_REQ: begin
                if (disp_ack) begin
                    d.st = ST_IDLE;
                    unique case (kind)
                        HK_REJECT: begin
                            clr[q.cur] = 1'b1;
                            d.reject   = 1'b1;
                        end
                        HK_PLAIN: begin
                            d.exec_go = 1'b1;
                            d.st      = ST_SETTLE;
                        end
                        default: begin
                            clr[q.cur] = 1'b1;
                            d.q_tag    = dec_tag;
                            if (q_clash) d.clash = 1'b1;
                            else         d.q_go  = 1'b1;
                        end
                    endcase
                end
            end
            default: begin
                d.st = ST_IDLE;
                if (!eng_idle) begin
                    d.bvalid = 1'b1;
                    d.bslot  = q.cur;
                end else begin
                    clr[q.cur] = 1'b1;
                end
            end
        endcase

        if (q.bvalid && eng_idle) begin
            clr[q.bslot] = 1'b1;
            d.bvalid     = 1'b0;
        end

        d.issue = (q.issue & ~clr) | (issue_wr ? issue_wdata : '0);

        if (port_rst) begin
            d.st      = ST_IDLE;
            d.issue   = '0;
            d.bvalid  = 1'b0;
            d.bslot   = '0;
            d.exec_go = 1'b0;
            d.q_go    = 1'b0;
            d.reject  = 1'b0;
            d.clash   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign disp_req     = (q.st == ST_REQ);
    assign disp_slot    = q.cur;
    assign exec_go      = q.exec_go;
    assign q_go         = q.q_go;
    assign q_tag        = q.q_tag;
    assign disp_reject  = q.reject;
    assign tag_conflict = q.clash;
    assign issue_map    = q.issue;
    assign busy_valid   = q.bvalid;
    assign busy_slot    = q.bslot;
endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 port_rst,
    input logic                 start,
    input logic                 issue_wr,
    input logic [NUM_SLOTS-1:0] issue_wdata,
    input logic                 eng_bsy,
    input logic                 eng_drq,
    input logic                 disp_req,
    input logic [SLOT_W-1:0]    disp_slot,
    input logic                 exec_go,
    input logic                 q_go,
    input logic                 disp_reject,
    input logic                 tag_conflict,
    input logic [NUM_SLOTS-1:0] issue_map,
    input logic                 busy_valid
);
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_req) |-> (($past(issue_map) & ((NUM_SLOTS'(1) << disp_slot) - NUM_SLOTS'(1))) == '0)); // R1
    AST_SCAN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_req) |-> $past(start && !eng_bsy && !eng_drq)); // R3
    AST_WRITE_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue_wr) && !$past(port_rst) |-> ((issue_map & $past(issue_wdata)) == $past(issue_wdata))); // R2
    AST_RETIRE_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_valid && !eng_bsy && !eng_drq |=> !busy_valid); // R5
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_req) |-> !$past(busy_valid)); // R10
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exec_go, q_go, disp_reject, tag_conflict})); // R6
    AST_PORT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        port_rst |=> (issue_map == '0) && !busy_valid && !disp_req); // R11
endmodule

bind slot_dispatch_sched sds_checker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_rst     (port_rst),
    .start        (start),
    .issue_wr     (issue_wr),
    .issue_wdata  (issue_wdata),
    .eng_bsy      (eng_bsy),
    .eng_drq      (eng_drq),
    .disp_req     (disp_req),
    .disp_slot    (disp_slot),
    .exec_go      (exec_go),
    .q_go         (q_go),
    .disp_reject  (disp_reject),
    .tag_conflict (tag_conflict),
    .issue_map    (issue_map),
    .busy_valid   (busy_valid)
);

// File: tb/slot_dispatch_sched_bench.sv
module slot_dispatch_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 32;
    localparam int NT = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          port_rst = 1'b0;
    logic          start = 1'b0;
    logic          issue_wr = 1'b0;
    logic [NS-1:0] issue_wdata = '0;
    logic          eng_bsy = 1'b0;
    logic          eng_drq = 1'b0;
    logic          disp_req;
    logic [4:0]    disp_slot;
    logic          disp_ack = 1'b0;
    logic [7:0]    hdr_type = '0, hdr_flags = '0, hdr_cmd = '0, hdr_tag = '0;
    logic          exec_go, q_go, disp_reject, tag_conflict;
    logic [4:0]    q_tag;
    logic [NS-1:0] issue_map;
    logic          busy_valid;
    logic [4:0]    busy_slot;
    logic          cpl_valid = 1'b0;
    logic [4:0]    cpl_tag = '0;
    logic          cpl_err = 1'b0;
    logic          act_rd = 1'b0;
    logic [NT-1:0] act_rdata, fin_map, err_map;
    logic [7:0]    tf_status, tf_error;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slot_dispatch_sched u_slot_dispatch_sched (
        .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .start(start),
        .issue_wr(issue_wr), .issue_wdata(issue_wdata),
        .eng_bsy(eng_bsy), .eng_drq(eng_drq),
        .disp_req(disp_req), .disp_slot(disp_slot), .disp_ack(disp_ack),
        .hdr_type(hdr_type), .hdr_flags(hdr_flags), .hdr_cmd(hdr_cmd), .hdr_tag(hdr_tag),
        .exec_go(exec_go), .q_go(q_go), .q_tag(q_tag),
        .disp_reject(disp_reject), .tag_conflict(tag_conflict),
        .issue_map(issue_map), .busy_valid(busy_valid), .busy_slot(busy_slot),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_err(cpl_err),
        .act_rd(act_rd), .act_rdata(act_rdata), .fin_map(fin_map), .err_map(err_map),
        .tf_status(tf_status), .tf_error(tf_error)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_issue(logic [NS-1:0] m);
        issue_wr = 1'b1;
        issue_wdata = m;
        step();
        issue_wr = 1'b0;
        issue_wdata = '0;
    endtask

    task automatic offer(int exp_slot, logic [7:0] t, logic [7:0] f, logic [7:0] c, logic [7:0] g);
        int n = 0;
        while (!disp_req && n < 40) begin
            step();
            n++;
        end
        chk("R1 offered slot", {27'd0, disp_slot}, exp_slot);
        hdr_type = t; hdr_flags = f; hdr_cmd = c; hdr_tag = g;
        disp_ack = 1'b1;
        step();
        disp_ack = 1'b0;
    endtask

    task automatic run_plain(int s, int busy_n);
        offer(s, 8'h27, 8'h80, 8'hC8, 8'h00);
        chk("R6 plain exec_go", {31'd0, exec_go}, 1);
        if (busy_n > 0) begin
            eng_bsy = 1'b1;
            step();
            chk("R5 busy_valid", {31'd0, busy_valid}, 1);
            chk("R5 busy_slot", {27'd0, busy_slot}, s);
            for (int k = 0; k < busy_n; k++) step();
            chk("R10 no offer while busy", {31'd0, disp_req}, 0);
            chk("R5 bit held", {31'd0, issue_map[s]}, 1);
            eng_bsy = 1'b0;
            step();
            chk("R5 retired bit", {31'd0, issue_map[s]}, 0);
            chk("R5 busy cleared", {31'd0, busy_valid}, 0);
        end else begin
            step();
            chk("R4 bit cleared", {31'd0, issue_map[s]}, 0);
        end
    endtask

    task automatic run_queued(int s, logic [7:0] c, int tag, bit exp_clash);
        offer(s, 8'h27, 8'h80, c, 8'(tag << 3));
        chk("R7 q_go", {31'd0, q_go}, exp_clash ? 0 : 1);
        chk("R7 tag_conflict", {31'd0, tag_conflict}, exp_clash ? 1 : 0);
        if (!exp_clash) chk("R7 q_tag", {27'd0, q_tag}, tag);
        chk("R7 issue cleared", {31'd0, issue_map[s]}, 0);
    endtask

    task automatic complete(int tag, bit err);
        cpl_valid = 1'b1; cpl_tag = 5'(tag); cpl_err = err;
        step();
        cpl_valid = 1'b0; cpl_err = 1'b0;
    endtask

    initial begin
        logic [NS-1:0] rem;
        int lo;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R11 reset issue", issue_map, 0);
        chk("R1 reset no req", {31'd0, disp_req}, 0);
        chk("R5 reset busy", {31'd0, busy_valid}, 0);
        chk("R9 reset act", act_rdata, 0);

        // R1/R2: stopped port holds ORed bits, offers nothing
        wr_issue(32'h1);
        wr_issue(32'h4);
        wr_issue(32'h0);
        chk("R2 or-write", issue_map, 32'h5);
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R1 no offer when stopped", {31'd0, disp_req}, 0);
        end
        start = 1'b1;
        run_plain(0, 0);
        run_plain(2, 0);

        // R1/R4: sweep every slot
        for (int s = 0; s < NS; s++) begin
            wr_issue(NS'(1) << s);
            run_plain(s, 0);
        end

        // R1/R5/R10: ascending order over a multi-bit pattern with a long command
        wr_issue(32'h8001_0421);
        rem = 32'h8001_0421;
        while (rem != 0) begin
            lo = 0;
            for (int i = NS - 1; i >= 0; i--) if (rem[i]) lo = i;
            run_plain(lo, (lo == 5) ? 3 : 0);
            rem[lo] = 1'b0;
        end

        // R3: engine DRQ blocks the scan
        eng_drq = 1'b1;
        wr_issue(32'h80);
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R3 no offer while drq", {31'd0, disp_req}, 0);
        end
        chk("R3 bit kept", {31'd0, issue_map[7]}, 1);
        eng_drq = 1'b0;
        run_plain(7, 0);

        // R6: rejected frames
        wr_issue(32'h200);
        offer(9, 8'h34, 8'h80, 8'hC8, 8'h00);
        chk("R6 reject type", {31'd0, disp_reject}, 1);
        chk("R6 no exec", {31'd0, exec_go}, 0);
        chk("R6 bit cleared", {31'd0, issue_map[9]}, 0);
        wr_issue(32'h400);
        offer(10, 8'h27, 8'h00, 8'h60, 8'h18);
        chk("R6 reject flags", {31'd0, disp_reject}, 1);
        chk("R6 no queue", {31'd0, q_go}, 0);

        // R7: queued commands and tag clash
        wr_issue(32'h10);
        run_queued(4, 8'h60, 3, 0);
        chk("R7 active bit", act_rdata, 32'h8);
        wr_issue(32'h40);
        run_queued(6, 8'h61, 3, 1);
        chk("R7 clash keeps act", act_rdata, 32'h8);
        wr_issue(32'h100);
        run_queued(8, 8'h61, 10, 0);
        chk("R7 second tag", act_rdata, 32'h408);

        // R8: completions
        complete(3, 1);
        chk("R8 act cleared", act_rdata, 32'h400);
        chk("R8 fin", fin_map, 32'h8);
        chk("R8 err map", err_map, 32'h8);
        chk("R8 status err", {24'd0, tf_status}, 32'h41);
        chk("R8 error abort", {24'd0, tf_error}, 32'h04);
        complete(10, 0);
        chk("R8 fin two", fin_map, 32'h408);
        chk("R8 status ok", {24'd0, tf_status}, 32'h50);
        chk("R8 error kept", {24'd0, tf_error}, 32'h04);

        // R9: reuse a finished tag, then read the active view
        wr_issue(32'h1);
        run_queued(0, 8'h60, 3, 0);
        wr_issue(32'h2);
        run_queued(1, 8'h60, 12, 0);
        chk("R9 view masks finished", act_rdata, 32'h1000);
        act_rd = 1'b1;
        step();
        act_rd = 1'b0;
        chk("R9 fin zeroed", fin_map, 0);
        chk("R9 finished dropped", act_rdata, 32'h1000);

        // R11: port reset with busy slot and pending bits
        wr_issue(32'h2);
        offer(1, 8'h27, 8'h80, 8'hC8, 8'h00);
        eng_bsy = 1'b1;
        step();
        chk("R5 busy before reset", {31'd0, busy_valid}, 1);
        start = 1'b0;
        wr_issue(32'hF0);
        complete(12, 0);
        wr_issue(32'h0);
        port_rst = 1'b1;
        step();
        port_rst = 1'b0;
        chk("R11 issue cleared", issue_map, 0);
        chk("R11 busy dropped", {31'd0, busy_valid}, 0);
        chk("R11 fin cleared", fin_map, 0);
        eng_bsy = 1'b0;
        start = 1'b1;
        wr_issue(32'h4);
        run_queued(2, 8'h61, 3, 0);
        chk("R11 tags freed", act_rdata, 32'h8);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule